// File: doc/BRIEF.md
# Scratchpad Memory with Parity Detection and Duplicate-Copy Recovery

This block is a small on-chip scratchpad that keeps two copies of every line. The primary copy serves the processor. The replica copy lives in a separate store that models a cache set aside as a mirror. Each stored word carries a 4-lane interleaved parity code. Because of this code, any run of up to four neighbouring flipped bits disturbs four different lanes, so the error is always seen.

A read returns one cycle after it is accepted when the primary word is clean. When the primary word fails its parity, the controller does three things. It fetches the line's replica, hands back the replica data one cycle later, and writes that data over the damaged primary line. Writes update the primary at once. The matching replica update goes into a four-entry queue, which drains into the replica store only on cycles when that store is otherwise unused. When the replica also fails its parity, the damaged primary data is returned, an uncorrectable flag is raised, and nothing is written back.

The processor sees an ordinary one-request-at-a-time read/write port with a ready/valid handshake. A fault injection port can flip chosen bits of either copy, so that the recovery paths can be exercised.

Top module: `spm_dup_ctrl`

## Requirements
- R1: After reset every line of both copies reads as zero with a clean code, `req_ready` is high, and `rsp_valid`, `err_corrected` and `err_uncorrectable` are low.
- R2: A read of a line with a clean primary word returns the last data written there with `rsp_valid` high exactly one cycle after acceptance, and both error flags low.
- R3: A stored word is 36 bits: data in bits 31..0 and parity in bits 35..32. Bit 32+i is the XOR (even parity) of the data bits whose index modulo 4 equals i. Only a mismatch of this code counts as an error, so two flips in the same lane go unseen.
- R4: Any burst of 1 to 4 adjacent flipped bits anywhere in a primary word is corrected. The response arrives two cycles after acceptance and carries the replica data, and `err_corrected` is high for exactly that one cycle.
- R5: After a correction the primary line holds the repaired word, so the next read of it returns in one cycle with no flag.
- R6: A replica fetch takes the newest queued duplicate write for that line in preference to the replica store.
- R7: The duplicate-write queue holds 4 entries. It drains one entry on each cycle in which no request is accepted and no replica fetch occurs. While it is full, `req_ready` is low for writes but stays high for reads.
- R8: When both copies fail parity, the response comes two cycles after acceptance with the unchanged primary data and `err_uncorrectable` high. The primary line is not rewritten, so a repeat read flags again.
- R9: Only one request is in flight: `req_ready` is low from the cycle after a read is accepted until its response cycle has passed.
- R10: An injection pulse XORs `inj_mask` into the 36-bit word of line `inj_addr` in the copy chosen by `inj_replica` (1 = replica store). Other lines are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Line index |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| err_corrected | output | 1 | One-cycle pulse: response was taken from the replica |
| err_uncorrectable | output | 1 | Both copies failed parity on this response |
| inj_valid | input | 1 | Apply a fault mask this cycle |
| inj_replica | input | 1 | Mask targets the replica store (1) or the primary (0) |
| inj_addr | input | 4 | Line the mask applies to |
| inj_mask | input | 36 | Bits to flip in the stored word |

## Verification
Some properties are checked by assertions on every cycle:
- the correction flag lasts a single cycle and always comes with a response;
- the two flags never occur together;
- a write is never accepted while the queue is full;
- the queue occupancy stays within bounds;
- no request is accepted while a response is pending;
- a read that does not answer in the first cycle always answers, with a flag, in the second.

Other behaviour only the bench scenarios can show:
- the corrected data value;
- the repair of the primary line;
- that every 1- to 4-bit burst at every position of every line is caught;
- that the queue supplies the newest pending value;
- that same-lane double flips slip through the parity.

// File: rtl/spm_dup_pkg.sv
package spm_dup_pkg;
    // Interleave degree of the parity code.
    localparam int LANES = 4;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CHECK = 2'd1,
        PH_REPL  = 2'd2
    } phase_e;
endpackage

// File: rtl/spm_lane_parity.sv
module spm_lane_parity #(
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [LANES-1:0]  par_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin : lane_xor
            logic acc;
            acc = 1'b0;
            for (int j = g; j < DATA_W; j += LANES) begin
                acc = acc ^ data_i[j];
            end
            par_o[g] = acc;
        end
    end
endmodule

// File: rtl/spm_line_store.sv
module spm_line_store #(
    parameter int WORD_W = 36,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              flip_en,
    input  logic [AW-1:0]     flip_addr,
    input  logic [WORD_W-1:0] flip_mask,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [WORD_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
        if (flip_en) begin
            mem_d[flip_addr] = mem_d[flip_addr] ^ flip_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/spm_dup_queue.sv
module spm_dup_queue #(
    parameter int AW     = 4,
    parameter int WORD_W = 36,
    parameter int DEPTH  = 4,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [AW-1:0]     push_addr,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    output logic              full,
    output logic              empty,
    output logic [CW-1:0]     count,
    output logic [AW-1:0]     head_addr,
    output logic [WORD_W-1:0] head_word,
    input  logic [AW-1:0]     look_addr,
    output logic              look_hit,
    output logic [WORD_W-1:0] look_word
);
    typedef struct packed {
        logic [PW-1:0] head;
        logic [CW-1:0] count;
    } ctl_t;

    ctl_t              ctl_q, ctl_d;
    logic [AW-1:0]     ent_addr_q [DEPTH];
    logic [AW-1:0]     ent_addr_d [DEPTH];
    logic [WORD_W-1:0] ent_word_q [DEPTH];
    logic [WORD_W-1:0] ent_word_d [DEPTH];
    logic [PW-1:0]     tail;

    always_comb begin
        ctl_d      = ctl_q;
        ent_addr_d = ent_addr_q;
        ent_word_d = ent_word_q;
        tail       = ctl_q.head + PW'(ctl_q.count);
        if (push) begin
            ent_addr_d[tail] = push_addr;
            ent_word_d[tail] = push_word;
        end
        if (pop) begin
            ctl_d.head = ctl_q.head + PW'(1);
        end
        ctl_d.count = ctl_q.count + CW'(push) - CW'(pop);
    end

    // Scan oldest to newest so the newest matching entry wins.
    always_comb begin
        logic [PW-1:0] idx;
        look_hit  = 1'b0;
        look_word = '0;
        for (int i = 0; i < DEPTH; i++) begin
            idx = ctl_q.head + PW'(i);
            if (CW'(i) < ctl_q.count && ent_addr_q[idx] == look_addr) begin
                look_hit  = 1'b1;
                look_word = ent_word_q[idx];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ent_addr_q <= '{default: '0};
            ent_word_q <= '{default: '0};
        end else begin
            ctl_q      <= ctl_d;
            ent_addr_q <= ent_addr_d;
            ent_word_q <= ent_word_d;
        end
    end

    assign full      = (ctl_q.count == CW'(DEPTH));
    assign empty     = (ctl_q.count == '0);
    assign count     = ctl_q.count;
    assign head_addr = ent_addr_q[ctl_q.head];
    assign head_word = ent_word_q[ctl_q.head];
endmodule

// File: rtl/spm_dup_ctrl.sv
module spm_dup_ctrl
    import spm_dup_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int DEPTH      = 16,
    parameter int WBUF_DEPTH = 4,
    localparam int AW        = $clog2(DEPTH),
    localparam int WORD_W    = DATA_W + LANES,
    localparam int WCW       = $clog2(WBUF_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              err_corrected,
    output logic              err_uncorrectable,
    input  logic              inj_valid,
    input  logic              inj_replica,
    input  logic [AW-1:0]     inj_addr,
    input  logic [WORD_W-1:0] inj_mask
);
    typedef struct packed {
        phase_e            phase;
        logic [AW-1:0]     addr;
        logic [WORD_W-1:0] p_word;
        logic [WORD_W-1:0] r_word;
    } st_t;

    st_t st_q, st_d;

    logic [LANES-1:0]  wr_par, p_par, r_par;
    logic [WORD_W-1:0] wr_word;
    logic              acc, p_ok, r_ok, fetch, repair;

    logic              prim_we;
    logic [AW-1:0]     prim_waddr;
    logic [WORD_W-1:0] prim_wdata, prim_rdata;
    logic [WORD_W-1:0] repl_rdata, fetch_word;

    logic              wb_push, wb_pop, wb_full, wb_empty, wb_hit;
    logic [WCW-1:0]    wb_count;
    logic [AW-1:0]     wb_head_addr;
    logic [WORD_W-1:0] wb_head_word, wb_hit_word;

    spm_lane_parity #(.DATA_W(DATA_W), .LANES(LANES)) u_par_wr (
        .data_i(req_wdata), .par_o(wr_par)
    );
    spm_lane_parity #(.DATA_W(DATA_W), .LANES(LANES)) u_par_prim (
        .data_i(st_q.p_word[DATA_W-1:0]), .par_o(p_par)
    );
    spm_lane_parity #(.DATA_W(DATA_W), .LANES(LANES)) u_par_repl (
        .data_i(st_q.r_word[DATA_W-1:0]), .par_o(r_par)
    );

    assign wr_word = {wr_par, req_wdata};

    spm_line_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_prim (
        .clk(clk), .rst_n(rst_n),
        .we(prim_we), .waddr(prim_waddr), .wdata(prim_wdata),
        .flip_en(inj_valid && !inj_replica), .flip_addr(inj_addr), .flip_mask(inj_mask),
        .raddr(req_addr), .rdata(prim_rdata)
    );

    spm_line_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_repl (
        .clk(clk), .rst_n(rst_n),
        .we(wb_pop), .waddr(wb_head_addr), .wdata(wb_head_word),
        .flip_en(inj_valid && inj_replica), .flip_addr(inj_addr), .flip_mask(inj_mask),
        .raddr(st_q.addr), .rdata(repl_rdata)
    );

    spm_dup_queue #(.AW(AW), .WORD_W(WORD_W), .DEPTH(WBUF_DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(wb_push), .push_addr(req_addr), .push_word(wr_word),
        .pop(wb_pop), .full(wb_full), .empty(wb_empty), .count(wb_count),
        .head_addr(wb_head_addr), .head_word(wb_head_word),
        .look_addr(st_q.addr), .look_hit(wb_hit), .look_word(wb_hit_word)
    );

    always_comb begin
        st_d       = st_q;
        req_ready  = (st_q.phase == PH_IDLE) && !(req_write && wb_full);
        acc        = req_valid && req_ready;
        p_ok       = (p_par == st_q.p_word[DATA_W +: LANES]);
        r_ok       = (r_par == st_q.r_word[DATA_W +: LANES]);
        fetch      = (st_q.phase == PH_CHECK) && !p_ok;
        repair     = (st_q.phase == PH_REPL) && r_ok;
        fetch_word = wb_hit ? wb_hit_word : repl_rdata;

        // Primary: processor writes, or the repair of a damaged line.
        prim_we    = (acc && req_write) || repair;
        prim_waddr = repair ? st_q.addr : req_addr;
        prim_wdata = repair ? st_q.r_word : wr_word;

        // Replica queue: fill on writes, drain on otherwise unused cycles.
        wb_push    = acc && req_write;
        wb_pop     = !acc && !fetch && !wb_empty;

        case (st_q.phase)
            PH_IDLE: begin
                if (acc && !req_write) begin
                    st_d.phase  = PH_CHECK;
                    st_d.addr   = req_addr;
                    st_d.p_word = prim_rdata;
                end
            end
            PH_CHECK: begin
                if (p_ok) begin
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.phase  = PH_REPL;
                    st_d.r_word = fetch_word;
                end
            end
            PH_REPL: begin
                st_d.phase = PH_IDLE;
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase

        rsp_valid         = ((st_q.phase == PH_CHECK) && p_ok) || (st_q.phase == PH_REPL);
        rsp_rdata         = repair ? st_q.r_word[DATA_W-1:0] : st_q.p_word[DATA_W-1:0];
        err_corrected     = repair;
        err_uncorrectable = (st_q.phase == PH_REPL) && !r_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/spm_dup_chk.sv
module spm_dup_chk #(
    parameter int WBUF_DEPTH = 4,
    localparam int WCW       = $clog2(WBUF_DEPTH + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_write,
    input logic           req_ready,
    input logic           rsp_valid,
    input logic           err_corrected,
    input logic           err_uncorrectable,
    input logic           wb_full,
    input logic [WCW-1:0] wb_count
);
    logic rd_acc;
    assign rd_acc = req_valid && req_ready && !req_write;

    // R4
    corr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_corrected |=> !err_corrected);

    // R4
    corr_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_corrected |-> rsp_valid);

    // R8
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_corrected && err_uncorrectable));

    // R8
    uncorr_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_uncorrectable |-> rsp_valid);

    // R7
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && wb_full) |-> !req_ready);

    // R7
    queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_count <= WCW'(WBUF_DEPTH));

    // R9
    single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R2
    first_cycle_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> (!err_corrected && !err_uncorrectable));

    // R4
    second_cycle_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc ##1 !rsp_valid) |=> (rsp_valid && (err_corrected || err_uncorrectable)));
endmodule

bind spm_dup_ctrl spm_dup_chk #(.WBUF_DEPTH(WBUF_DEPTH)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .err_corrected(err_corrected),
    .err_uncorrectable(err_uncorrectable),
    .wb_full(wb_full),
    .wb_count(wb_count)
);

// File: tb/spm_dup_ctrl_tb.sv
`timescale 1ns/1ps
module spm_dup_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, err_corrected, err_uncorrectable;
    logic [31:0] rsp_rdata;
    logic        inj_valid = 1'b0, inj_replica = 1'b0;
    logic [3:0]  inj_addr = '0;
    logic [35:0] inj_mask = '0;

    int n_cmp = 0;
    int n_bad = 0;
    logic [35:0] prim [16];
    logic [35:0] repl [16];

    always #2 clk = ~clk;

    spm_dup_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .err_corrected(err_corrected), .err_uncorrectable(err_uncorrectable),
        .inj_valid(inj_valid), .inj_replica(inj_replica),
        .inj_addr(inj_addr), .inj_mask(inj_mask)
    );

    function automatic logic [35:0] enc(logic [31:0] d);
        logic [3:0] p = '0;
        for (int j = 0; j < 32; j++) p[j % 4] = p[j % 4] ^ d[j];
        return {p, d};
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(int a, logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a[3:0]; req_wdata = d;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        prim[a] = enc(d);
        repl[a] = enc(d);
    endtask

    // R6: write and corrupt the fresh primary word in the same cycle.
    task automatic write_corrupt(int a, logic [31:0] d, logic [35:0] m);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a[3:0]; req_wdata = d;
        inj_valid = 1'b1; inj_replica = 1'b0; inj_addr = a[3:0]; inj_mask = m;
        #1;
        check("R6 ready", req_ready, 1);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; inj_valid = 1'b0;
        prim[a] = enc(d) ^ m;
        repl[a] = enc(d);
    endtask

    task automatic inject(logic to_repl, int a, logic [35:0] m);
        inj_valid = 1'b1; inj_replica = to_repl; inj_addr = a[3:0]; inj_mask = m;
        @(posedge clk); @(negedge clk);
        inj_valid = 1'b0;
        if (to_repl) repl[a] = repl[a] ^ m;
        else prim[a] = prim[a] ^ m;
    endtask

    task automatic do_read(int a, string tag);
        logic [35:0] pe, re;
        logic [31:0] ed;
        int el, lat;
        logic ec, eu;
        pe = prim[a];
        ec = 1'b0; eu = 1'b0; el = 1; ed = pe[31:0];
        if (enc(pe[31:0]) != pe) begin
            re = repl[a];
            el = 2;
            if (enc(re[31:0]) == re) begin
                ed = re[31:0]; ec = 1'b1; prim[a] = re;
            end else begin
                eu = 1'b1;
            end
        end
        req_valid = 1'b1; req_write = 1'b0; req_addr = a[3:0];
        #1;
        check({tag, " R9 ready idle"}, req_ready, 1);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        if (!rsp_valid) begin
            check({tag, " R2 no early flag"}, {err_corrected, err_uncorrectable}, 0);
            @(negedge clk);
            lat = 2;
        end
        check({tag, " valid"}, rsp_valid, 1);
        check({tag, " latency"}, lat, el);
        check({tag, " data"}, rsp_rdata, ed);
        check({tag, " corrected"}, err_corrected, ec);
        check({tag, " uncorrectable"}, err_uncorrectable, eu);
        check({tag, " R9 busy"}, req_ready, 0);
        @(negedge clk);
        check({tag, " R4 pulse end"}, err_corrected, 0);
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin prim[i] = '0; repl[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 ready", req_ready, 1);
        check("R1 rsp_valid", rsp_valid, 0);
        check("R1 flags", {err_corrected, err_uncorrectable}, 0);
        @(negedge clk);
        for (int a = 0; a < 16; a++) do_read(a, "R1 zero line");

        // R2 back-to-back writes (queue stalls and drains), then clean reads
        for (int a = 0; a < 16; a++) do_write(a, 32'hA5C3_0F1E ^ (a * 32'h0101_0111));
        for (int a = 0; a < 16; a++) do_read(a, "R2 clean read");
        repeat (8) @(negedge clk);

        // R3 same-lane double flip is invisible; cross-lane double flip is seen
        inject(1'b0, 2, 36'h11);
        do_read(2, "R3 same lane undetected");
        do_write(2, 32'h1357_9BDF);
        repeat (8) @(negedge clk);
        inject(1'b0, 2, 36'h3);
        do_read(2, "R3 two lanes detected");

        // R4/R5 every burst of 1..4 bits at every position of every line
        for (int a = 0; a < 16; a++) begin
            for (int len = 1; len <= 4; len++) begin
                for (int s = 0; s <= 36 - len; s++) begin
                    inject(1'b0, a, ((36'd1 << len) - 36'd1) << s);
                    do_read(a, "R4 burst corrected");
                    do_read(a, "R5 repaired line");
                end
            end
        end

        // R6 replica fetch uses pending queued writes, newest first
        repeat (8) @(negedge clk);
        write_corrupt(9, 32'hDEAD_BEEF, 36'h1);
        do_read(9, "R6 pending entry");
        repeat (8) @(negedge clk);
        do_write(10, 32'h0BAD_F00D);
        write_corrupt(10, 32'h600D_CAFE, 36'hF_0000_0000);
        do_read(10, "R6 newest entry");

        // R7 queue full stalls writes only, then drains
        repeat (8) @(negedge clk);
        for (int a = 0; a < 4; a++) do_write(a, 32'h7700_0000 + a);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd4; req_wdata = 32'h7700_0004;
        #1;
        check("R7 write stalled when full", req_ready, 0);
        req_write = 1'b0;
        #0.5;
        check("R7 read allowed when full", req_ready, 1);
        req_valid = 1'b0; req_write = 1'b1;
        @(negedge clk);
        req_valid = 1'b1;
        #1;
        check("R7 write allowed after drain", req_ready, 1);
        req_valid = 1'b0;
        @(negedge clk);
        do_write(4, 32'h7700_0004);
        repeat (8) @(negedge clk);
        for (int a = 0; a < 5; a++) begin
            inject(1'b0, a, 36'h1 << (a * 3));
            do_read(a, "R7 drained replica");
        end

        // R8 both copies damaged
        repeat (8) @(negedge clk);
        inject(1'b1, 5, 36'h8);
        inject(1'b0, 5, 36'h80);
        do_read(5, "R8 uncorrectable");
        do_read(5, "R8 not repaired");
        do_write(5, 32'h5555_AAAA);
        repeat (8) @(negedge clk);
        do_read(5, "R8 rewritten");

        // R10 injection touches only the chosen line
        inject(1'b0, 6, 36'hC);
        do_read(7, "R10 neighbour clean");
        do_read(6, "R10 target corrected");
        inject(1'b1, 8, 36'h2);
        do_read(8, "R10 replica-only fault hidden");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule